// File: doc/BRIEF.md
# Programmed-I/O Device Flag Controller

This block is the device-side logic for one peripheral attached to a shared programmed-I/O bus. It recognises its own 6-bit device code on the bus and keeps a two-flag device state: Busy, which means the device is working, and Done, which means a unit of data is finished. It also keeps an interrupt-disable bit. Each bus command can carry a flag control function and a word transfer at the same time. The transfer targets one of three holding buffers named A, B and C. A command can instead ask for one of four flag tests, and the answer returns on a skip line.

A completion strobe stands in for the real device. It moves a busy device to the Done state. When Done is set and interrupts are not disabled, the device raises a request. The request takes part in a positional priority chain. During an acknowledge cycle, the requester nearest the processor places its own code on the read bus, and it blocks every device further down the chain. A global I/O reset returns the device to idle. The bus runs at a fixed timing and has no back-pressure: a command is one clock wide, and read data and the skip answer are valid in that same cycle. Unselected devices drive zero onto the read bus so that the bus can be wired-OR.

Top module: `pio_device_ctrl`

## Requirements
- R1: The device acts on a command only when `cmd_valid` is high and `cmd_code` equals `DEV_CODE` (default octal 12). Codes 00 and 77 octal never select a device. An unselected command leaves the flags unchanged and returns a zero word and a low skip.
- R2: Control field `cmd_ctl`=01 (start) leaves Busy=1 and Done=0 after the clock edge. The control field applies whenever `cmd_xfer` is not 111.
- R3: Control field 10 (clear) leaves Busy=0 and Done=0 after the clock edge.
- R4: Control field 11 (pulse) drives `dev_pulse` high for the one cycle after the command and does not change the flags. Control field 00 changes nothing.
- R5: A `dev_complete` strobe while Busy=1 leaves Busy=0 and Done=1. A strobe while Busy=0 is ignored.
- R6: When a start or clear function and `dev_complete` arrive in the same cycle, the control function decides the flags. A pulse or no-op function lets the completion take effect.
- R7: `irq` is high exactly while Done=1 and the interrupt-disable bit is 0. A `mask_load` loads the interrupt-disable bit from `mask_word[MASK_BIT]` (default bit 5), whatever the device code on the bus.
- R8: With `cmd_xfer`=111, `cmd_ctl` selects a test, and `skip` answers it in the same cycle: 00 skips if Busy=1, 01 skips if Busy=0, 10 skips if Done=1, 11 skips if Done=0.
- R9: `cmd_xfer` values 010, 100 and 110 write the low bits of `bus_wdata` into buffers A, B and C (widths 8, 16 and 12). Values 001, 011 and 101 read A, B and C in the same cycle, with the unused upper bits returned as zero.
- R10: `pri_out` equals `pri_in` while `irq` is low and is 0 while `irq` is high. In a cycle with `intack` high, `pri_in` high and `irq` high, `bus_rdata` carries `DEV_CODE` zero-extended. Otherwise an acknowledge cycle returns zero.
- R11: `io_reset` clears Busy, Done and interrupt-disable. It takes precedence over any command, completion or mask load in the same cycle.
- R12: Busy and Done are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_reset | input | 1 | Global synchronous I/O reset |
| cmd_valid | input | 1 | Bus command present this cycle |
| cmd_code | input | 6 | Device code of the command |
| cmd_xfer | input | 3 | Transfer kind, or 111 for a flag test |
| cmd_ctl | input | 2 | Control function, or the test selector |
| bus_wdata | input | WORD_W | Word written by data-out commands |
| bus_rdata | output | WORD_W | Data-in word or acknowledge code, zero otherwise |
| skip | output | 1 | Flag test satisfied |
| mask_load | input | 1 | Broadcast of the interrupt mask word |
| mask_word | input | WORD_W | Interrupt mask word |
| intack | input | 1 | Interrupt acknowledge cycle |
| pri_in | input | 1 | Priority from the device nearer the processor |
| pri_out | output | 1 | Priority to the next device |
| irq | output | 1 | Interrupt request |
| dev_complete | input | 1 | Device finished a unit of data |
| dev_pulse | output | 1 | Special device-specific pulse |
| busy | output | 1 | Busy flag |
| done | output | 1 | Done flag |

## Verification
A completion from the device can land in the same cycle as a processor control function, and the flag outcome of that collision is the hazard here. The bench first puts the device into Busy. It then raises `dev_complete` in the same cycle as a clear command, then as a start command, then as a pulse command. After each edge it reads Busy and Done from the ports and compares them with the R6 precedence rule. It also checks that a start combined with an I/O reset ends in the idle state.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [2:0] {
    XF_NONE  = 3'b000,
    XF_IN_A  = 3'b001,
    XF_OUT_A = 3'b010,
    XF_IN_B  = 3'b011,
    XF_OUT_B = 3'b100,
    XF_IN_C  = 3'b101,
    XF_OUT_C = 3'b110,
    XF_TEST  = 3'b111
  } xfer_e;

  typedef enum logic [1:0] {
    CF_NONE  = 2'b00,
    CF_START = 2'b01,
    CF_CLEAR = 2'b10,
    CF_PULSE = 2'b11
  } ctl_e;

  typedef enum logic [1:0] {
    TS_BUSY_SET = 2'b00,
    TS_BUSY_CLR = 2'b01,
    TS_DONE_SET = 2'b10,
    TS_DONE_CLR = 2'b11
  } test_e;

  localparam int NUM_BUFS = 3;
  localparam int CODE_W   = 6;
endpackage

// File: rtl/pio_sel_decode.sv
module pio_sel_decode
  import pio_pkg::*;
#(
  parameter logic [CODE_W-1:0] DEV_CODE = 6'o12
) (
  input  logic                cmd_valid,
  input  logic [CODE_W-1:0]   cmd_code,
  input  logic [2:0]          cmd_xfer,
  input  logic [1:0]          cmd_ctl,
  output logic                sel,
  output logic                do_start,
  output logic                do_clear,
  output logic                do_pulse,
  output logic                do_test,
  output logic [NUM_BUFS-1:0] buf_wr,
  output logic [NUM_BUFS-1:0] buf_rd
);
  localparam logic [CODE_W-1:0] CODE_NONE = '0;
  localparam logic [CODE_W-1:0] CODE_CPU  = '1;
  localparam bit CODE_LEGAL = (DEV_CODE != CODE_NONE) && (DEV_CODE != CODE_CPU);

  xfer_e xf;
  ctl_e  cf;
  logic  ctl_ok;

  assign xf     = xfer_e'(cmd_xfer);
  assign cf     = ctl_e'(cmd_ctl);
  assign sel    = CODE_LEGAL && cmd_valid && (cmd_code == DEV_CODE);
  assign do_test = sel && (xf == XF_TEST);
  assign ctl_ok = sel && (xf != XF_TEST);

  assign do_start = ctl_ok && (cf == CF_START);
  assign do_clear = ctl_ok && (cf == CF_CLEAR);
  assign do_pulse = ctl_ok && (cf == CF_PULSE);

  always_comb begin
    buf_wr = '0;
    buf_rd = '0;
    if (sel) begin
      unique case (xf)
        XF_IN_A:  buf_rd[0] = 1'b1;
        XF_OUT_A: buf_wr[0] = 1'b1;
        XF_IN_B:  buf_rd[1] = 1'b1;
        XF_OUT_B: buf_wr[1] = 1'b1;
        XF_IN_C:  buf_rd[2] = 1'b1;
        XF_OUT_C: buf_wr[2] = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pio_flag_fsm.sv
module pio_flag_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic io_reset,
  input  logic do_start,
  input  logic do_clear,
  input  logic complete,
  input  logic mask_load,
  input  logic mask_bit,
  output logic busy,
  output logic done,
  output logic int_dis
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      int_dis <= 1'b0;
    end else if (io_reset) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      int_dis <= 1'b0;
    end else begin
      if (mask_load) int_dis <= mask_bit;
      if (do_start) begin
        busy <= 1'b1;
        done <= 1'b0;
      end else if (do_clear) begin
        busy <= 1'b0;
        done <= 1'b0;
      end else if (complete && busy) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pio_buffers.sv
module pio_buffers
  import pio_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int A_W    = 8,
  parameter int B_W    = 16,
  parameter int C_W    = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_BUFS-1:0] buf_wr,
  input  logic [NUM_BUFS-1:0] buf_rd,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata
);
  function automatic int width_of(input int idx);
    case (idx)
      0:       return A_W;
      1:       return B_W;
      default: return C_W;
    endcase
  endfunction

  logic [WORD_W-1:0] rd_word [NUM_BUFS];
  logic [WORD_W-1:0] unused_wdata;
  assign unused_wdata = wdata;

  for (genvar gi = 0; gi < NUM_BUFS; gi++) begin : g_buf
    localparam int W = width_of(gi);
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= '0;
      else if (buf_wr[gi]) q <= wdata[W-1:0];
    end
    assign rd_word[gi] = WORD_W'(q);
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_BUFS; i++) begin
      if (buf_rd[i]) rdata = rdata | rd_word[i];
    end
  end
endmodule

// File: rtl/pio_pri_link.sv
module pio_pri_link
  import pio_pkg::*;
#(
  parameter int                WORD_W   = 16,
  parameter logic [CODE_W-1:0] DEV_CODE = 6'o12
) (
  input  logic              done,
  input  logic              int_dis,
  input  logic              intack,
  input  logic              pri_in,
  output logic              irq,
  output logic              pri_out,
  output logic [WORD_W-1:0] ack_word
);
  logic ack_hit;

  assign irq      = done && !int_dis;
  assign pri_out  = pri_in && !irq;
  assign ack_hit  = intack && pri_in && irq;
  assign ack_word = ack_hit ? WORD_W'(DEV_CODE) : '0;
endmodule

// File: rtl/pio_device_ctrl.sv
module pio_device_ctrl
  import pio_pkg::*;
#(
  parameter int                WORD_W   = 16,
  parameter logic [CODE_W-1:0] DEV_CODE = 6'o12,
  parameter int                MASK_BIT = 5,
  parameter int                A_W      = 8,
  parameter int                B_W      = 16,
  parameter int                C_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_reset,
  input  logic              cmd_valid,
  input  logic [5:0]        cmd_code,
  input  logic [2:0]        cmd_xfer,
  input  logic [1:0]        cmd_ctl,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              skip,
  input  logic              mask_load,
  input  logic [WORD_W-1:0] mask_word,
  input  logic              intack,
  input  logic              pri_in,
  output logic              pri_out,
  output logic              irq,
  input  logic              dev_complete,
  output logic              dev_pulse,
  output logic              busy,
  output logic              done
);
  logic                sel, do_start, do_clear, do_pulse, do_test, int_dis;
  logic [NUM_BUFS-1:0] buf_wr, buf_rd;
  logic [WORD_W-1:0]   buf_rdata, ack_word;
  logic [WORD_W-1:0]   unused_mask;
  logic                unused_sel;

  assign unused_mask = mask_word;
  assign unused_sel  = sel;

  pio_sel_decode #(.DEV_CODE(DEV_CODE)) i_dec (
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_xfer(cmd_xfer),
    .cmd_ctl(cmd_ctl), .sel(sel), .do_start(do_start), .do_clear(do_clear),
    .do_pulse(do_pulse), .do_test(do_test), .buf_wr(buf_wr), .buf_rd(buf_rd)
  );

  pio_flag_fsm i_flags (
    .clk(clk), .rst_n(rst_n), .io_reset(io_reset), .do_start(do_start),
    .do_clear(do_clear), .complete(dev_complete), .mask_load(mask_load),
    .mask_bit(mask_word[MASK_BIT]), .busy(busy), .done(done), .int_dis(int_dis)
  );

  pio_buffers #(.WORD_W(WORD_W), .A_W(A_W), .B_W(B_W), .C_W(C_W)) i_bufs (
    .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_rd(buf_rd),
    .wdata(bus_wdata), .rdata(buf_rdata)
  );

  pio_pri_link #(.WORD_W(WORD_W), .DEV_CODE(DEV_CODE)) i_pri (
    .done(done), .int_dis(int_dis), .intack(intack), .pri_in(pri_in),
    .irq(irq), .pri_out(pri_out), .ack_word(ack_word)
  );

  assign bus_rdata = buf_rdata | ack_word;

  always_comb begin
    skip = 1'b0;
    if (do_test) begin
      unique case (test_e'(cmd_ctl))
        TS_BUSY_SET: skip = busy;
        TS_BUSY_CLR: skip = !busy;
        TS_DONE_SET: skip = done;
        TS_DONE_CLR: skip = !done;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dev_pulse <= 1'b0;
    else        dev_pulse <= do_pulse && !io_reset;
  end
endmodule

// File: rtl/pio_device_ctrl_chk.sv
module pio_device_ctrl_chk #(
  parameter int         WORD_W   = 16,
  parameter logic [5:0] DEV_CODE = 6'o12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_reset,
  input logic              cmd_valid,
  input logic [5:0]        cmd_code,
  input logic [2:0]        cmd_xfer,
  input logic [1:0]        cmd_ctl,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              skip,
  input logic              intack,
  input logic              pri_in,
  input logic              pri_out,
  input logic              irq,
  input logic              busy,
  input logic              done
);
  logic mine_ctl;
  assign mine_ctl = cmd_valid && (cmd_code == DEV_CODE) && (cmd_xfer != 3'b111) && !io_reset;

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R12
  AST_START_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (mine_ctl && cmd_ctl == 2'b01) |=> (busy && !done)); // R2
  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (mine_ctl && cmd_ctl == 2'b10) |=> (!busy && !done)); // R3
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    io_reset |=> (!busy && !done && !irq)); // R11
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy)); // R5
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done); // R7
  AST_CHAIN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pri_out |-> (pri_in && !irq)); // R10
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 6'o77 && !intack) |-> (bus_rdata == '0 && !skip)); // R1
endmodule

bind pio_device_ctrl pio_device_ctrl_chk #(.WORD_W(WORD_W), .DEV_CODE(DEV_CODE)) i_chk (.*);

// File: tb/test_pio_device_ctrl.sv
`timescale 1ns/1ps
module test_pio_device_ctrl;
  localparam int         W    = 16;
  localparam logic [5:0] CODE = 6'o12;

  logic clk = 1'b0, rst_n = 1'b0, io_reset = 1'b0;
  logic cmd_valid = 1'b0;
  logic [5:0] cmd_code = '0;
  logic [2:0] cmd_xfer = '0;
  logic [1:0] cmd_ctl = '0;
  logic [W-1:0] bus_wdata = '0, mask_word = '0;
  logic mask_load = 1'b0, intack = 1'b0, pri_in = 1'b0, dev_complete = 1'b0;
  logic [W-1:0] bus_rdata;
  logic skip, pri_out, irq, dev_pulse, busy, done;
  int n_checks = 0, n_fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pio_device_ctrl i_pio_device_ctrl (
    .clk(clk), .rst_n(rst_n), .io_reset(io_reset), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_xfer(cmd_xfer), .cmd_ctl(cmd_ctl),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .skip(skip),
    .mask_load(mask_load), .mask_word(mask_word), .intack(intack),
    .pri_in(pri_in), .pri_out(pri_out), .irq(irq), .dev_complete(dev_complete),
    .dev_pulse(dev_pulse), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input logic eb, input logic ed);
    chk(busy === eb && done === ed, req, {14'd0, busy, done}, {14'd0, eb, ed});
  endtask

  task automatic idle();
    cmd_valid = 0; cmd_code = '0; cmd_xfer = '0; cmd_ctl = '0; bus_wdata = '0;
    mask_load = 0; mask_word = '0; intack = 0; dev_complete = 0; io_reset = 0;
  endtask

  task automatic put(input logic [5:0] c, input logic [2:0] x, input logic [1:0] f, input logic [W-1:0] d);
    cmd_valid = 1; cmd_code = c; cmd_xfer = x; cmd_ctl = f; bus_wdata = d;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic do_cmd(input logic [5:0] c, input logic [2:0] x, input logic [1:0] f);
    put(c, x, f, '0);
    step();
  endtask

  task automatic t_reset();
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_flags("R12 reset state", 0, 0);
    chk(irq === 0 && dev_pulse === 0 && bus_rdata === '0, "R7 reset outputs", {15'd0, irq}, '0);
  endtask

  task automatic t_select();
    do_cmd(6'o13, 3'b000, 2'b01);
    chk_flags("R1 other code ignored", 0, 0);
    do_cmd(6'o77, 3'b000, 2'b01);
    chk_flags("R1 code 77 ignored", 0, 0);
    do_cmd(6'o00, 3'b000, 2'b01);
    chk_flags("R1 code 00 ignored", 0, 0);
    put(CODE, 3'b000, 2'b01, '0); cmd_valid = 0;
    step();
    chk_flags("R1 no valid ignored", 0, 0);
    put(6'o77, 3'b111, 2'b01, '0); #1;
    chk(skip === 0 && bus_rdata === '0, "R1 code 77 test quiet", {15'd0, skip}, '0);
    step();
  endtask

  task automatic t_start_clear();
    do_cmd(CODE, 3'b000, 2'b01);
    chk_flags("R2 start", 1, 0);
    do_cmd(CODE, 3'b000, 2'b00);
    chk_flags("R4 no-op keeps", 1, 0);
    do_cmd(CODE, 3'b000, 2'b10);
    chk_flags("R3 clear", 0, 0);
  endtask

  task automatic t_pulse();
    do_cmd(CODE, 3'b000, 2'b01);
    put(CODE, 3'b000, 2'b11, '0);
    @(posedge clk); #1;
    chk(dev_pulse === 1, "R4 pulse high", {15'd0, dev_pulse}, 16'd1);
    @(negedge clk); idle();
    chk_flags("R4 pulse keeps flags", 1, 0);
    @(posedge clk); #1;
    chk(dev_pulse === 0, "R4 pulse one cycle", {15'd0, dev_pulse}, '0);
    @(negedge clk);
    do_cmd(CODE, 3'b000, 2'b10);
  endtask

  task automatic t_complete();
    dev_complete = 1; step();
    chk_flags("R5 completion when idle ignored", 0, 0);
    do_cmd(CODE, 3'b000, 2'b01);
    dev_complete = 1; step();
    chk_flags("R5 completion sets done", 0, 1);
    chk(irq === 1, "R7 irq on done", {15'd0, irq}, 16'd1);
    do_cmd(CODE, 3'b000, 2'b01);
    chk_flags("R2 start clears done", 1, 0);
  endtask

  task automatic t_collide();
    put(CODE, 3'b000, 2'b10, '0); dev_complete = 1; step();
    chk_flags("R6 clear beats completion", 0, 0);
    do_cmd(CODE, 3'b000, 2'b01);
    put(CODE, 3'b000, 2'b01, '0); dev_complete = 1; step();
    chk_flags("R6 start beats completion", 1, 0);
    put(CODE, 3'b000, 2'b11, '0); dev_complete = 1; step();
    chk_flags("R6 completion with pulse", 0, 1);
    do_cmd(CODE, 3'b000, 2'b01);
    put(CODE, 3'b000, 2'b01, '0); io_reset = 1; step();
    chk_flags("R11 reset beats start", 0, 0);
  endtask

  task automatic t_mask();
    do_cmd(CODE, 3'b000, 2'b01);
    dev_complete = 1; step();
    mask_load = 1; mask_word = 16'h0020; step();
    chk(irq === 0, "R7 mask bit 5 disables", {15'd0, irq}, '0);
    mask_load = 1; mask_word = 16'hFFDF; step();
    chk(irq === 1, "R7 other mask bits ignored", {15'd0, irq}, 16'd1);
    mask_load = 1; mask_word = 16'h0020; step();
    io_reset = 1; step();
    do_cmd(CODE, 3'b000, 2'b01);
    dev_complete = 1; step();
    chk(irq === 1, "R11 reset clears disable", {15'd0, irq}, 16'd1);
    do_cmd(CODE, 3'b000, 2'b10);
  endtask

  task automatic t_skip(input logic eb, input logic ed, input string tag);
    logic exp;
    for (int t = 0; t < 4; t++) begin
      put(CODE, 3'b111, t[1:0], '0); #1;
      case (t)
        0: exp = eb;
        1: exp = !eb;
        2: exp = ed;
        default: exp = !ed;
      endcase
      chk(skip === exp, {"R8 skip test ", tag}, {15'd0, skip}, {15'd0, exp});
      step();
    end
  endtask

  task automatic t_skips();
    t_skip(0, 0, "idle");
    do_cmd(CODE, 3'b000, 2'b01);
    t_skip(1, 0, "busy");
    chk_flags("R8 test leaves flags", 1, 0);
    dev_complete = 1; step();
    t_skip(0, 1, "done");
    do_cmd(CODE, 3'b000, 2'b10);
  endtask

  task automatic t_buffers();
    put(CODE, 3'b010, 2'b00, 16'hBEEF); step();
    put(CODE, 3'b100, 2'b00, 16'hBEEF); step();
    put(CODE, 3'b110, 2'b00, 16'hBEEF); step();
    put(6'o13, 3'b010, 2'b00, 16'h1234); step();
    put(CODE, 3'b001, 2'b00, '0); #1;
    chk(bus_rdata === 16'h00EF, "R9 buffer A zero fill", bus_rdata, 16'h00EF); step();
    put(CODE, 3'b011, 2'b00, '0); #1;
    chk(bus_rdata === 16'hBEEF, "R9 buffer B full", bus_rdata, 16'hBEEF); step();
    put(CODE, 3'b101, 2'b00, '0); #1;
    chk(bus_rdata === 16'h0EEF, "R9 buffer C zero fill", bus_rdata, 16'h0EEF); step();
    put(6'o13, 3'b001, 2'b00, '0); #1;
    chk(bus_rdata === '0, "R1 read other code is zero", bus_rdata, '0); step();
    put(CODE, 3'b001, 2'b01, '0); #1;
    chk(bus_rdata === 16'h00EF, "R9 read with start", bus_rdata, 16'h00EF); step();
    chk_flags("R2 start with transfer", 1, 0);
    do_cmd(CODE, 3'b000, 2'b10);
  endtask

  task automatic t_chain();
    pri_in = 1; #1;
    chk(pri_out === 1, "R10 pass when idle", {15'd0, pri_out}, 16'd1);
    do_cmd(CODE, 3'b000, 2'b01);
    dev_complete = 1; step();
    intack = 1; pri_in = 1; #1;
    chk(bus_rdata === 16'o12 && pri_out === 0, "R10 ack returns code", bus_rdata, 16'o12);
    pri_in = 0; #1;
    chk(bus_rdata === '0 && pri_out === 0, "R10 blocked upstream", bus_rdata, '0);
    step(); pri_in = 1;
    do_cmd(CODE, 3'b000, 2'b10);
    intack = 1; #1;
    chk(bus_rdata === '0 && pri_out === 1, "R10 no request no code", bus_rdata, '0);
    step(); pri_in = 0;
  endtask

  initial begin
    t_reset();
    t_select();
    t_start_clear();
    t_pulse();
    t_complete();
    t_collide();
    t_mask();
    t_skips();
    t_buffers();
    t_chain();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule